// File: doc/BRIEF.md
# CPU Clock Video Standard Detector

This block tells the video logic which timing family the host machine runs. It measures the host CPU clock against a free-running reference clock. The answer is either PAL-B, or the family that shares the faster CPU clock (NTSC, PAL-N and PAL-M). The CPU clock is brought into the reference domain, and its rising edges are counted over fixed windows of reference cycles. Each finished window is sorted into one of three classes: fast, slow, or inside a hysteresis band around the 1.04 MHz boundary. With the defaults (50 MHz reference, 1 ms window) the band spans 1036 to 1044 edges.

Early readings are distrusted, because a clock may run fast for a while after power-up. Nothing is decided until a settle period has passed with the settle enable held high. The period is 100 ms by default. After that, the block changes its answer only after a run of consecutive windows that all oppose the current answer. It can change in either direction. Every change raises a single-cycle request for the pixel-clock PLL to be reprogrammed.

Top module: `clk_std_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, `is_ntsc` is 0 (0 = PAL-B, 1 = NTSC family), `pll_reconfig` is 0 and `std_valid` is 0.
- R2: `std_valid` rises at the end of the SETTLE_CYCLES-th consecutive reference cycle in which `settle_en` is sampled high. A low sample before then restarts the count from zero. Once high, `std_valid` stays high until reset.
- R3: No measurement window that closes at or before the cycle in which the settle period completes can influence `is_ntsc`. The first window that counts is the first one that begins after settling.
- R4: A window is fast when its edge count is above CNT_HI, and fast windows argue for NTSC family (`is_ntsc` = 1). A window is slow when its count is below CNT_LO, and slow windows argue for PAL-B (`is_ntsc` = 0).
- R5: `is_ntsc` changes only after AGREE_N consecutive counted windows that each oppose its current value. Any counted window that does not oppose it restarts the run.
- R6: Each change of `is_ntsc` comes with `pll_reconfig` high for exactly one reference cycle, in the same cycle as the new value. `pll_reconfig` is never high at any other time.
- R7: Switching works in both directions: PAL-B to NTSC family, and NTSC family back to PAL-B.
- R8: Windows whose count lies from CNT_LO to CNT_HI inclusive never move `is_ntsc`, from either state.
- R9: The CPU clock passes through a two-flop synchroniser. Each of its rising edges adds exactly one to the count of the window in which it is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk | input | 1 | Host CPU clock, asynchronous to ref_clk |
| settle_en | input | 1 | Settle timer runs only while high |
| is_ntsc | output | 1 | 0 = PAL-B, 1 = NTSC family |
| pll_reconfig | output | 1 | One-cycle request to reprogram the pixel-clock PLL |
| std_valid | output | 1 | High once the settle period has completed |

## Verification
Two events can land in the same cycle: the settle period completing, and a measurement window closing. With `settle_en` high from reset and SETTLE_CYCLES a multiple of WIN_CYCLES, both happen on the same edge. The bench sets up exactly that case and feeds a fast clock from time zero. It then checks that the switch pulse appears AGREE_N full windows after the first window that starts after settling. It must not appear one window earlier, which is what would happen if the coinciding window were wrongly counted.

// File: rtl/std_det_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the CPU clock video standard detector.
// Assumes: none; pure type definitions.
package std_det_pkg;

    // Selected video timing family.
    typedef enum logic {
        STD_PAL  = 1'b0,
        STD_NTSC = 1'b1
    } vid_std_e;

    // Classification of one finished measurement window.
    typedef enum logic [1:0] {
        WIN_SLOW = 2'd0,
        WIN_BAND = 2'd1,
        WIN_FAST = 2'd2
    } win_class_e;

endpackage

// File: rtl/cpu_clk_sync.sv
`timescale 1ns/1ps
// Module: cpu_clk_sync
// Brings an asynchronous clock into the reference domain through a
// SYNC_STAGES-deep flop chain and emits a one-cycle pulse per rising edge.
// Assumes: the sampled clock is slower than half the reference clock.
module cpu_clk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Shift the asynchronous level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
        end
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    // Rising edge of the synchronised level.
    always_comb rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R9

endmodule

// File: rtl/edge_window_counter.sv
`timescale 1ns/1ps
// Module: edge_window_counter
// Counts edge pulses over back-to-back windows of WIN_CYCLES reference
// cycles. At each window end it presents the total with a one-cycle strobe.
// Assumes: edge pulses are never high in two consecutive cycles.
module edge_window_counter #(
    parameter int WIN_CYCLES = 50000,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic             win_done_o,
    output logic [CNT_W-1:0] win_count_o
);

    localparam int WIN_W = $clog2(WIN_CYCLES);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'((WIN_CYCLES + 1) / 2);

    logic [WIN_W-1:0] pos_q;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] acc_next;

    // Running total including the edge seen in this cycle.
    always_comb acc_next = acc_q + {{(CNT_W-1){1'b0}}, edge_i};

    // Advance the window position and accumulate, publishing at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            acc_q       <= '0;
            win_done_o  <= 1'b0;
            win_count_o <= '0;
        end else if (pos_q == WIN_LAST) begin
            pos_q       <= '0;
            acc_q       <= '0;
            win_done_o  <= 1'b1;
            win_count_o <= acc_next;
        end else begin
            pos_q       <= pos_q + 1'b1;
            acc_q       <= acc_next;
            win_done_o  <= 1'b0;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_o |-> (win_count_o <= CNT_MAX)); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_o |=> !win_done_o); // R9

endmodule

// File: rtl/std_decider.sv
`timescale 1ns/1ps
// Module: std_decider
// Runs the power-up settle timer, classifies each finished window with
// hysteresis, and switches the standard after AGREE_N consecutive opposing
// windows, issuing one reconfiguration pulse per switch.
// Assumes: win_done_i is a one-cycle strobe with win_count_i valid alongside.
module std_decider
    import std_det_pkg::*;
#(
    parameter int SETTLE_CYCLES = 5000000,
    parameter int AGREE_N       = 8,
    parameter int CNT_HI        = 1044,
    parameter int CNT_LO        = 1036,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             settle_en_i,
    input  logic             win_done_i,
    input  logic [CNT_W-1:0] win_count_i,
    output logic             is_ntsc_o,
    output logic             reconfig_o,
    output logic             valid_o
);

    localparam int ST_W = $clog2(SETTLE_CYCLES + 1);
    localparam int AG_W = $clog2(AGREE_N + 1);
    localparam logic [ST_W-1:0]  ST_LAST = ST_W'(SETTLE_CYCLES - 1);
    localparam logic [AG_W-1:0]  AG_LAST = AG_W'(AGREE_N - 1);
    localparam logic [CNT_W-1:0] HI_C    = CNT_W'(CNT_HI);
    localparam logic [CNT_W-1:0] LO_C    = CNT_W'(CNT_LO);

    logic [ST_W-1:0] settle_q;
    logic            settled_q;
    logic            armed_q;
    logic [AG_W-1:0] agree_q;
    vid_std_e        mode_q;
    logic            pulse_q;
    win_class_e      win_class;
    logic            opposes;

    // Sort the finished window into fast, slow or in-band.
    always_comb begin
        if (win_count_i > HI_C)      win_class = WIN_FAST;
        else if (win_count_i < LO_C) win_class = WIN_SLOW;
        else                         win_class = WIN_BAND;
    end

    // A window opposes the current standard when it points the other way.
    always_comb opposes = ((mode_q == STD_PAL)  && (win_class == WIN_FAST)) ||
                          ((mode_q == STD_NTSC) && (win_class == WIN_SLOW));

    // Settle timer: counts enabled cycles, restarts on a low enable, sticks when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q  <= '0;
            settled_q <= 1'b0;
        end else if (!settled_q) begin
            if (!settle_en_i)            settle_q  <= '0;
            else if (settle_q == ST_LAST) settled_q <= 1'b1;
            else                          settle_q  <= settle_q + 1'b1;
        end
    end

    // Arm at the first window boundary after settling; vote and switch afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            agree_q <= '0;
            mode_q  <= STD_PAL;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (win_done_i) begin
                if (!armed_q) begin
                    armed_q <= settled_q;
                end else if (opposes) begin
                    if (agree_q == AG_LAST) begin
                        agree_q <= '0;
                        mode_q  <= (mode_q == STD_PAL) ? STD_NTSC : STD_PAL;
                        pulse_q <= 1'b1;
                    end else begin
                        agree_q <= agree_q + 1'b1;
                    end
                end else begin
                    agree_q <= '0;
                end
            end
        end
    end

    // Drive the outputs from the state registers.
    always_comb begin
        is_ntsc_o  = (mode_q == STD_NTSC);
        reconfig_o = pulse_q;
        valid_o    = settled_q;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R6

    AST_PULSE_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> pulse_q); // R6

    AST_QUIET_BEFORE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        !settled_q |-> (!pulse_q && (mode_q == STD_PAL) && !armed_q)); // R3

    AST_AGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        agree_q <= AG_LAST); // R5

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        settled_q |=> settled_q); // R2

    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done_i && (win_class == WIN_BAND)) |=> $stable(mode_q)); // R8

endmodule

// File: rtl/clk_std_detect.sv
`timescale 1ns/1ps
// Module: clk_std_detect (top)
// Decides PAL-B versus NTSC-family timing from the host CPU clock frequency
// and requests a pixel-clock PLL reprogram on every change of decision.
// Assumes: ref_clk is free running and at least twice the CPU clock rate.
// Defaults: 50 MHz reference, 1 ms window, boundary 1.04 MHz, 100 ms settle.
module clk_std_detect #(
    parameter int WIN_CYCLES    = 50000,
    parameter int CNT_HI        = 1044,
    parameter int CNT_LO        = 1036,
    parameter int AGREE_N       = 8,
    parameter int SETTLE_CYCLES = 5000000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic cpu_clk,
    input  logic settle_en,
    output logic is_ntsc,
    output logic pll_reconfig,
    output logic std_valid
);

    localparam int CNT_W = $clog2(WIN_CYCLES + 1);

    logic             cpu_rise;
    logic             win_done;
    logic [CNT_W-1:0] win_count;

    cpu_clk_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .async_i (cpu_clk),
        .rise_o  (cpu_rise)
    );

    edge_window_counter #(
        .WIN_CYCLES (WIN_CYCLES),
        .CNT_W      (CNT_W)
    ) win_i (
        .clk         (ref_clk),
        .rst_n       (rst_n),
        .edge_i      (cpu_rise),
        .win_done_o  (win_done),
        .win_count_o (win_count)
    );

    std_decider #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .AGREE_N       (AGREE_N),
        .CNT_HI        (CNT_HI),
        .CNT_LO        (CNT_LO),
        .CNT_W         (CNT_W)
    ) dec_i (
        .clk         (ref_clk),
        .rst_n       (rst_n),
        .settle_en_i (settle_en),
        .win_done_i  (win_done),
        .win_count_i (win_count),
        .is_ntsc_o   (is_ntsc),
        .reconfig_o  (pll_reconfig),
        .valid_o     (std_valid)
    );

endmodule

// File: tb/clk_std_detect_tb_top.sv
`timescale 1ns/1ps
// Directed bench: 200 MHz reference, window 100 cycles, settle 500 cycles,
// 4 agreeing windows. Slow CPU clock gives ~10 edges, fast ~25, band ~20.
module clk_std_detect_tb_top;

    localparam real SLOW_HALF = 25.0;
    localparam real FAST_HALF = 10.0;
    localparam real BAND_HALF = 12.5;

    logic ref_clk   = 1'b0;
    logic rst_n     = 1'b0;
    logic cpu_clk   = 1'b0;
    logic settle_en = 1'b1;
    logic is_ntsc;
    logic pll_reconfig;
    logic std_valid;

    real cpu_half = SLOW_HALF;
    int  cyc;
    int  pulse_cnt;
    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    clk_std_detect #(
        .WIN_CYCLES    (100),
        .CNT_HI        (22),
        .CNT_LO        (18),
        .AGREE_N       (4),
        .SETTLE_CYCLES (500),
        .SYNC_STAGES   (2)
    ) dut_i (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .cpu_clk      (cpu_clk),
        .settle_en    (settle_en),
        .is_ntsc      (is_ntsc),
        .pll_reconfig (pll_reconfig),
        .std_valid    (std_valid)
    );

    always #2.5 ref_clk = ~ref_clk;

    initial begin
        #1;
        forever #(cpu_half) cpu_clk = ~cpu_clk;
    end

    always @(posedge ref_clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge ref_clk) begin
        if (rst_n && pll_reconfig) pulse_cnt <= pulse_cnt + 1;
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) begin
            @(posedge ref_clk);
            #1;
        end
    endtask

    task automatic do_reset(input bit en);
        @(negedge ref_clk);
        rst_n     = 1'b0;
        settle_en = en;
        repeat (4) @(posedge ref_clk);
        #1;
        pulse_cnt = 0;
        @(negedge ref_clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4 R9: fast clock from reset; settle end coincides with a window end.
    task automatic test_overlap();
        cpu_half = FAST_HALF;
        do_reset(1'b1);
        #1;
        check("R1 is_ntsc in reset", is_ntsc, 0);
        check("R1 pll_reconfig in reset", pll_reconfig, 0);
        check("R1 std_valid in reset", std_valid, 0);
        wait_cyc(1);
        check("R1 is_ntsc after reset", is_ntsc, 0);
        check("R1 std_valid after reset", std_valid, 0);
        wait_cyc(499);
        check("R2 std_valid before settle", std_valid, 0);
        wait_cyc(500);
        check("R2 std_valid at settle", std_valid, 1);
        wait_cyc(900);
        check("R3 coinciding window ignored", is_ntsc, 0);
        check("R3 no early pulse", pulse_cnt, 0);
        wait_cyc(901);
        check("R4 R9 fast clock selects NTSC", is_ntsc, 1);
        check("R6 pulse with change", pll_reconfig, 1);
        wait_cyc(902);
        check("R6 pulse lasts one cycle", pll_reconfig, 0);
        check("R6 single pulse", pulse_cnt, 1);
    endtask

    // R4 R5 R7 R8: slow stays PAL, short fast burst rejected, both-way switching, band holds.
    task automatic test_switching();
        cpu_half = SLOW_HALF;
        do_reset(1'b1);
        wait_cyc(1000);
        check("R4 slow clock keeps PAL", is_ntsc, 0);
        check("R6 no pulse on PAL", pulse_cnt, 0);
        cpu_half = FAST_HALF;
        wait_cyc(1300);
        cpu_half = SLOW_HALF;
        wait_cyc(1590);
        check("R5 three fast windows not enough", is_ntsc, 0);
        check("R5 no pulse after burst", pulse_cnt, 0);
        wait_cyc(1600);
        cpu_half = FAST_HALF;
        wait_cyc(1995);
        check("R5 run restarted after slow window", is_ntsc, 0);
        wait_cyc(2005);
        check("R5 four fast windows switch", is_ntsc, 1);
        check("R6 one pulse to NTSC", pulse_cnt, 1);
        wait_cyc(2100);
        cpu_half = BAND_HALF;
        wait_cyc(3000);
        check("R8 band keeps NTSC", is_ntsc, 1);
        check("R8 no pulse in band", pulse_cnt, 1);
        cpu_half = SLOW_HALF;
        wait_cyc(3395);
        check("R7 NTSC held before full run", is_ntsc, 1);
        wait_cyc(3405);
        check("R7 slow clock returns to PAL", is_ntsc, 0);
        check("R7 one pulse back to PAL", pulse_cnt, 2);
        wait_cyc(3500);
        cpu_half = BAND_HALF;
        wait_cyc(4500);
        check("R8 band keeps PAL", is_ntsc, 0);
        check("R8 no pulse in band from PAL", pulse_cnt, 2);
    endtask

    // R2: settle timer needs consecutive enabled cycles and restarts on a low enable.
    task automatic test_settle_enable();
        cpu_half = FAST_HALF;
        do_reset(1'b0);
        wait_cyc(800);
        check("R2 no valid while enable low", std_valid, 0);
        check("R3 no decision while enable low", is_ntsc, 0);
        settle_en = 1'b1;
        wait_cyc(1000);
        settle_en = 1'b0;
        wait_cyc(1200);
        settle_en = 1'b1;
        wait_cyc(1699);
        check("R2 timer restarted by low enable", std_valid, 0);
        wait_cyc(1700);
        check("R2 valid after full settle", std_valid, 1);
        wait_cyc(2095);
        check("R3 first counted window after settle", is_ntsc, 0);
        wait_cyc(2105);
        check("R4 NTSC after settle and agreement", is_ntsc, 1);
        check("R6 single pulse after settle", pulse_cnt, 1);
    endtask

    initial begin
        test_overlap();
        test_switching();
        test_settle_enable();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule